// File: doc/BRIEF.md
# Masked Interrupt Status Unit with Read-To-Clear

This block gathers twelve interrupt sources of a serial bus controller into one raw status word, gates it with a software mask, and drives a single interrupt line. Ten of the sources are edge type. Their event pulses set sticky bits that software removes by reading a clear address: there is one clear address per source, and one address that clears all of them. The other two sources are level type and follow FIFO threshold comparisons. Reads do not clear them.

Alongside the status word, the block keeps a record of why the last transmit abort happened. Each abort event ORs a cause vector into that record. The record is wiped by the same reads that clear the abort status bit. Software must therefore read the cause record before it clears the abort.

Registers are reached through a plain read/write strobe port. Read data comes back registered, one cycle after the strobe. The event generators and the FIFOs themselves lie outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: Status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop detected, 10 start detected, 11 general call. A pulse on `src_evt[i]` of an edge source sets raw bit i on that clock edge, and the bit stays set until it is cleared. Pulses on `src_evt[2]` and `src_evt[4]` have no effect. The raw word reads at address 1.
- R2: The mask register is read/write at address 2 (bits 11:0). The masked status, equal to raw AND mask, reads at address 0.
- R3: If an event arrives in the same cycle as a clear read of its bit, the bit stays set.
- R4: A read of address 8+i clears only raw bit i. Reads of 10 and 12 (the level bits) change nothing.
- R5: A read of address 6 clears every edge bit and leaves bits 2 and 4 alone.
- R6: Bit 2 is registered from rx_level > rx threshold (address 3). Bit 4 is registered from tx_level <= tx threshold (address 4). Each is visible one cycle after the level input changes.
- R7: On a tx abort event, `abort_cause` is ORed into the cause record, which reads at address 5. A read of address 14 or of address 6 wipes the record. An abort in the same cycle as the wipe loads its own cause.
- R8: `irq` is the registered OR of the masked status. It rises one cycle after the raw bit is set and stays low while the mask is zero.
- R9: Reset clears mask, thresholds, raw bits, cause record, `irq` and `bus_rdata`.
- R10: `bus_rdata` carries the addressed value in the cycle after a read strobe and zero otherwise. Unmapped and clear addresses read zero. Writes to read-only addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 12 | Event pulses, one per source bit |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| abort_cause | input | ABRT_W | Cause vector sampled with a tx abort event |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Edge bits, level bits, the cause record and clear effects all land on the clock edge that samples the event, level or strobe. `irq` lands one edge after that. Read data is registered from the state that existed before the read's own edge. The bench therefore drives on falling edges and reads back only with a later strobe, so it never sees the raw word and the read in the same edge. It checks `irq` at the first and second falling edges after an event, to pin the one-cycle lag exactly.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NSRC = 12;

  localparam int B_RXUND = 0;
  localparam int B_RXOVR = 1;
  localparam int B_RXFUL = 2;
  localparam int B_TXOVR = 3;
  localparam int B_TXEMP = 4;
  localparam int B_RDREQ = 5;
  localparam int B_TXABT = 6;
  localparam int B_RXDON = 7;
  localparam int B_ACTIV = 8;
  localparam int B_STOPD = 9;
  localparam int B_STRTD = 10;
  localparam int B_GCALL = 11;

  localparam logic [NSRC-1:0] LEVEL_SRC = (NSRC'(1) << B_RXFUL) | (NSRC'(1) << B_TXEMP);
  localparam logic [NSRC-1:0] EDGE_SRC  = ~LEVEL_SRC;

  localparam int A_MSTAT  = 0;
  localparam int A_RAW    = 1;
  localparam int A_MASK   = 2;
  localparam int A_RXTHR  = 3;
  localparam int A_TXTHR  = 4;
  localparam int A_CAUSE  = 5;
  localparam int A_CLRALL = 6;
  localparam int A_CLRB   = 8;
endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSRC-1:0]   clr_vec,
  output logic              wipe_cause
);
  logic hit_all;

  always_comb hit_all = rd && (addr == ADDR_W'(A_CLRALL));

  for (genvar i = 0; i < NSRC; i++) begin : g_dec
    if (LEVEL_SRC[i]) begin : g_lvl
      assign clr_vec[i] = 1'b0;
    end else begin : g_edge
      assign clr_vec[i] = hit_all || (rd && (addr == ADDR_W'(A_CLRB + i)));
    end
  end

  always_comb wipe_cause = clr_vec[B_TXABT];
endmodule

// File: rtl/irq_raw_bank.sv
module irq_raw_bank
  import irq_stat_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  evt,
  input  logic [NSRC-1:0]  clr_vec,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_thr,
  output logic [NSRC-1:0]  raw
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (i == B_RXFUL) begin : g_rxf
      always_ff @(posedge clk) begin
        if (rst) raw[i] <= 1'b0;
        else     raw[i] <= (rx_level > rx_thr);
      end
    end else if (i == B_TXEMP) begin : g_txe
      always_ff @(posedge clk) begin
        if (rst) raw[i] <= 1'b0;
        else     raw[i] <= (tx_level <= tx_thr);
      end
    end else begin : g_edge
      always_ff @(posedge clk) begin
        if (rst)         raw[i] <= 1'b0;
        else if (evt[i]) raw[i] <= 1'b1;
        else if (clr_vec[i]) raw[i] <= 1'b0;
      end
    end
  end

  logic [NSRC-1:0] evt_e;
  logic [NSRC-1:0] clr_only;
  always_comb begin
    evt_e    = evt & EDGE_SRC;
    clr_only = clr_vec & ~evt & EDGE_SRC;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt_e) |=> ((raw & $past(evt_e)) == $past(evt_e))); // R3
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (|clr_only) |=> ((raw & $past(clr_only)) == '0)); // R4
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(|evt_e) && !(|clr_vec)) |=> $stable(raw & EDGE_SRC)); // R1
endmodule

// File: rtl/irq_cause_capture.sv
module irq_cause_capture #(
  parameter int ABRT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_evt,
  input  logic [ABRT_W-1:0] cause_in,
  input  logic              wipe,
  output logic [ABRT_W-1:0] cause
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
    end else if (abort_evt) begin
      cause <= wipe ? cause_in : (cause | cause_in);
    end else if (wipe) begin
      cause <= '0;
    end
  end

  AST_CAUSE_WIPE: assert property (@(posedge clk) disable iff (rst)
    (wipe && !abort_evt) |=> (cause == '0)); // R7
  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> ((cause & $past(cause_in)) == $past(cause_in))); // R7
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 5,
  parameter int ABRT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   raw,
  input  logic [ABRT_W-1:0] cause,
  output logic [NSRC-1:0]   mask,
  output logic [LVL_W-1:0]  rx_thr,
  output logic [LVL_W-1:0]  tx_thr,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(A_MASK))  mask   <= wdata[NSRC-1:0];
      if (addr == ADDR_W'(A_RXTHR)) rx_thr <= wdata[LVL_W-1:0];
      if (addr == ADDR_W'(A_TXTHR)) tx_thr <= wdata[LVL_W-1:0];
    end
  end

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (addr == ADDR_W'(A_MSTAT)) rmux = DATA_W'(raw & mask);
    if (addr == ADDR_W'(A_RAW))   rmux = DATA_W'(raw);
    if (addr == ADDR_W'(A_MASK))  rmux = DATA_W'(mask);
    if (addr == ADDR_W'(A_RXTHR)) rmux = DATA_W'(rx_thr);
    if (addr == ADDR_W'(A_TXTHR)) rmux = DATA_W'(tx_thr);
    if (addr == ADDR_W'(A_CAUSE)) rmux = DATA_W'(cause);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
    else         rdata <= '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mask)); // R2
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 5,
  parameter int ABRT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       src_evt,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [NSRC-1:0]   clr_vec;
  logic              wipe_cause;
  logic [NSRC-1:0]   raw;
  logic [NSRC-1:0]   mask;
  logic [LVL_W-1:0]  rx_thr;
  logic [LVL_W-1:0]  tx_thr;
  logic [ABRT_W-1:0] cause;

  irq_clr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd(bus_rd), .addr(bus_addr), .clr_vec(clr_vec), .wipe_cause(wipe_cause)
  );

  irq_raw_bank #(.LVL_W(LVL_W)) u_raw (
    .clk(clk), .rst(rst), .evt(src_evt), .clr_vec(clr_vec),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .raw(raw)
  );

  irq_cause_capture #(.ABRT_W(ABRT_W)) u_cause (
    .clk(clk), .rst(rst), .abort_evt(src_evt[B_TXABT]),
    .cause_in(abort_cause), .wipe(wipe_cause), .cause(cause)
  );

  irq_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .ABRT_W(ABRT_W)) u_csr (
    .clk(clk), .rst(rst), .rd(bus_rd), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .raw(raw), .cause(cause), .mask(mask),
    .rx_thr(rx_thr), .tx_thr(tx_thr), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw & mask);
  end

  AST_IRQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq); // R8
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    ((mask & src_evt & EDGE_SRC) != '0) |=> ##1 irq); // R8
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int AW = 5, DW = 16, LW = 5, CW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   src_evt = '0;
  logic [LW-1:0] rx_level = '0;
  logic [LW-1:0] tx_level = 5'd5;
  logic [CW-1:0] abort_cause = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst(rst), .src_evt(src_evt), .rx_level(rx_level),
    .tx_level(tx_level), .abort_cause(abort_cause), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [11:0] evt;
    logic [11:0] mask;
    logic [4:0]  rx;
    logic [4:0]  tx;
    logic [11:0] exp_raw;
    logic [11:0] exp_mst;
  } vec_t;

  // thresholds during the table: rx 3, tx 2
  localparam vec_t VEC [6] = '{
    '{12'h001, 12'hFFF, 5'd0,  5'd5,  12'h001, 12'h001},
    '{12'h804, 12'h000, 5'd0,  5'd5,  12'h800, 12'h000},
    '{12'h000, 12'h014, 5'd4,  5'd2,  12'h014, 12'h014},
    '{12'h3C0, 12'h0C0, 5'd3,  5'd3,  12'h3C0, 12'h0C0},
    '{12'h42A, 12'h400, 5'd31, 5'd0,  12'h43E, 12'h400},
    '{12'hFFF, 12'hAAA, 5'd0,  5'd31, 12'hFEB, 12'hAAA}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic [CW-1:0] c);
    src_evt = e; abort_cause = c;
    @(negedge clk);
    src_evt = '0; abort_cause = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    check("R9 irq in reset", 32'(irq), 0);
    check("R9 rdata in reset", 32'(bus_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    rd(1, d);  check("R9 raw after reset", 32'(d), 0);
    rd(2, d);  check("R9 mask after reset", 32'(d), 0);
    rd(5, d);  check("R9 cause after reset", 32'(d), 0);
    rd(3, d);  check("R9 rx thr after reset", 32'(d), 0);
    check("R9 irq after reset", 32'(irq), 0);

    wr(3, 16'd3);
    wr(4, 16'd2);

    // table walk: R1 R2 R6 R8
    for (int k = 0; k < 6; k++) begin
      rd(6, d);
      wr(2, 16'(VEC[k].mask));
      rx_level = VEC[k].rx; tx_level = VEC[k].tx;
      pulse(VEC[k].evt, 13'h001);
      rd(1, d);
      check($sformatf("R1 raw vec%0d", k), 32'(d), 32'(VEC[k].exp_raw));
      check($sformatf("R8 irq vec%0d", k), 32'(irq), 32'(VEC[k].exp_mst != 0));
      rd(0, d);
      check($sformatf("R2 masked vec%0d", k), 32'(d), 32'(VEC[k].exp_mst));
    end

    // R4 per-source clear
    rd(6, d); wr(2, 16'h0);
    rx_level = 0; tx_level = 31;
    pulse(12'h0A0, 0);
    rd(13, d);
    rd(1, d); check("R4 clear bit5 only", 32'(d), 32'h080);
    rx_level = 4; @(negedge clk);
    rd(10, d);
    rd(1, d); check("R4 level bit not cleared", 32'(d), 32'h084);

    // R3 set wins over clear
    pulse(12'h200, 0);
    bus_rd = 1'b1; bus_addr = AW'(17); src_evt = 12'h200;
    @(negedge clk);
    bus_rd = 1'b0; src_evt = '0;
    rd(1, d); check("R3 set wins", 32'(d), 32'h284);
    rd(17, d);
    rd(1, d); check("R3 later clear", 32'(d), 32'h084);

    // R5 global clear
    pulse(12'hA01, 0);
    rd(1, d); check("R5 before", 32'(d), 32'hA85);
    rd(6, d);
    rd(1, d); check("R5 global clear keeps level", 32'(d), 32'h004);

    // R6 threshold boundaries (rx thr 3, tx thr 2)
    rx_level = 3; tx_level = 31; @(negedge clk);
    rd(1, d); check("R6 rx equal thr", 32'(d), 32'h000);
    rx_level = 4; tx_level = 2; @(negedge clk);
    rd(1, d); check("R6 rx above, tx equal", 32'(d), 32'h014);
    tx_level = 3; @(negedge clk);
    rd(1, d); check("R6 tx above thr", 32'(d), 32'h004);

    // R7 abort cause
    rx_level = 0; tx_level = 31;
    pulse(12'h040, 13'h009);
    pulse(12'h040, 13'h100);
    rd(5, d); check("R7 cause accumulates", 32'(d), 32'h109);
    rd(14, d);
    rd(5, d); check("R7 cause wiped", 32'(d), 0);
    rd(1, d); check("R7 abort bit cleared", 32'(d), 0);
    bus_rd = 1'b1; bus_addr = AW'(6); src_evt = 12'h040; abort_cause = 13'h002;
    @(negedge clk);
    bus_rd = 1'b0; src_evt = '0; abort_cause = '0;
    rd(5, d); check("R7 new cause beats wipe", 32'(d), 32'h002);
    rd(1, d); check("R7 abort bit kept", 32'(d), 32'h040);

    // R8 irq timing
    rd(6, d);
    wr(2, 16'h001);
    src_evt = 12'h001;
    @(negedge clk);
    src_evt = '0;
    check("R8 irq not yet", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq one cycle later", 32'(irq), 1);
    rd(8, d);
    @(negedge clk);
    check("R8 irq drops after clear", 32'(irq), 0);
    wr(2, 16'h000);
    pulse(12'h001, 0);
    @(negedge clk);
    check("R8 irq masked off", 32'(irq), 0);
    rd(0, d); check("R2 masked zero", 32'(d), 0);
    rd(1, d); check("R2 raw still set", 32'(d), 32'h001);

    // R10 bus behaviour
    rd(31, d); check("R10 unmapped reads zero", 32'(d), 0);
    rd(8, d);  check("R10 clear address reads zero", 32'(d), 0);
    wr(1, 16'hFFFF);
    rd(1, d); check("R10 raw not writable", 32'(d), 0);
    wr(5, 16'h1FFF);
    rd(5, d); check("R10 cause not writable", 32'(d), 0);
    wr(2, 16'h0F0F);
    rd(2, d); check("R2 mask readback", 32'(d), 32'h0F0F);
    @(negedge clk);
    check("R10 rdata zero when idle", 32'(bus_rdata), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule